// File: doc/BRIEF.md
# Programmable Trigger Delay Channel with Half-Period Resolution

This block waits a programmed time after a trigger and then produces an output pulse. The trigger input is sampled on both edges of the fast clock, so the block knows which half of the clock period the trigger arrived in. The delay has three parts. A coarse counter advances once per group of eight fast clocks. A fine counter runs at the fast clock. A half-period bit adds half a clock. The output is driven by a pair of toggle registers, one per clock edge, so it can change on either edge. With a 500 MHz fast clock the delay step is 1 ns.

Settings are written through a simple parallel port into shadow registers. The running copy follows the shadow only while the channel is idle, so a write made during a delay never changes that delay. Pulse polarity and pulse width are programmable. A sticky overrun flag reports a trigger that arrived while the channel was still busy. That trigger is dropped. The flag is cleared by writing a one to the status address.

Top module: `trig_delay_channel`

## Requirements
- R1: After reset, `pulse_o` is low, `overrun_o` is low and the channel is idle.
- R2: Let a trigger be first seen high on a rising clock edge with number a, counting every clock edge. Edge a must follow an edge where the trigger was low. With coarse C, fine F and half bit H, the pulse starts on edge number a + 16*C + 2*F + H + 6. With all settings zero, this gives a fixed latency of six half-periods.
- R3: A trigger first seen on a falling edge uses the same formula with that edge's number. The output can therefore change on a falling edge. Setting H (bit 0 at address 2) moves the start one half period later.
- R4: The pulse lasts exactly 2*W clock edges, where W is written at address 3. A width of zero gives one clock period.
- R5: With polarity (bit 1 at address 2) set to one, the output rests high and the pulse is low.
- R6: A trigger that arrives before the previous pulse has ended does not change the output. It sets `overrun_o`, which then stays set.
- R7: Writing data bit 0 = 1 to address 4 clears `overrun_o`, and writing 0 there leaves it set. If a new overrun occurs in the same cycle as the clear, the flag stays set.
- R8: Writes to coarse (address 0, bits 7:0), fine (address 1), mode or width made while the channel is busy do not affect the current delay or pulse. The next trigger uses them.
- R9: The delay does not depend on the phase of the internal divide-by-eight counter when the trigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger input, sampled on both edges |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | DATA_W | Register write data |
| pulse_o | output | 1 | Delayed output pulse |
| overrun_o | output | 1 | Sticky retrigger-while-busy flag |

## Verification
Triggers are placed either just before a rising edge or just before a falling edge. This separates the two arrival phases, combined with the half bit both on and off. A sweep sends one coarse setting at eight different points of the divide-by-eight cycle, which exposes any phase error in the coarse-to-fine handover. Further runs cover the following cases:
- zero delay, which shows the bare latency;
- zero width;
- inverted polarity;
- a second trigger during a long delay, which shows the retrigger being dropped;
- writes made mid-delay, which show that a running delay is protected.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_COARSE = 2'd1,
    SEQ_FINE   = 2'd2,
    SEQ_PULSE  = 2'd3
  } seq_state_e;

  localparam int REG_ADDR_W = 3;
  localparam logic [REG_ADDR_W-1:0] REG_COARSE = 3'd0;
  localparam logic [REG_ADDR_W-1:0] REG_FINE   = 3'd1;
  localparam logic [REG_ADDR_W-1:0] REG_MODE   = 3'd2;
  localparam logic [REG_ADDR_W-1:0] REG_WIDTH  = 3'd3;
  localparam logic [REG_ADDR_W-1:0] REG_STATUS = 3'd4;

  // Output edge choice: falling-edge register when the requested half offset
  // and the detected arrival half disagree.
  function automatic logic edge_select(input logic half, input logic early);
    return half ^ early;
  endfunction

  // One extra fast cycle is needed when a half offset is asked for but the
  // trigger was seen on a rising edge.
  function automatic logic extra_cycle(input logic half, input logic early);
    return half & ~early;
  endfunction
endpackage

// File: rtl/tdc_edge_sampler.sv
`timescale 1ns/1ps
module tdc_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic det_o,
  output logic early_o
);
  logic neg_q;
  logic pos_q;
  logic neg_prev_q;
  logic pos_prev_q;
  logic rise_on_neg;
  logic rise_on_pos;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= trig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= 1'b0;
      neg_prev_q <= 1'b0;
      pos_prev_q <= 1'b0;
    end else begin
      pos_q      <= trig_i;
      neg_prev_q <= neg_q;
      pos_prev_q <= pos_q;
    end
  end

  // Samples in time order: pos_prev_q, neg_prev_q, pos_q (half a period apart)
  assign rise_on_neg = ~pos_prev_q & neg_prev_q;
  assign rise_on_pos = ~neg_prev_q & pos_q;
  assign det_o       = rise_on_neg | rise_on_pos;
  assign early_o     = rise_on_neg;
endmodule

// File: rtl/tdc_sequencer.sv
`timescale 1ns/1ps
module tdc_sequencer #(
  parameter int COARSE_W = 8,
  parameter int FINE_W   = 3,
  parameter int WIDTH_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                early_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  input  logic                half_i,
  input  logic [FINE_W-1:0]   fine_run_i,
  input  logic [WIDTH_W-1:0]  width_run_i,
  output logic                busy_o,
  output logic                go_o,
  output logic                stop_o,
  output logic                fall_edge_o
);
  import tdc_pkg::*;

  localparam int DIV_W  = 3;
  localparam int FCNT_W = FINE_W + 4;

  seq_state_e          state_q;
  logic [DIV_W-1:0]    div_q;
  logic                slow_tick;
  logic [COARSE_W-1:0] ccnt_q;
  logic [FCNT_W-1:0]   fcnt_q;
  logic [WIDTH_W-1:0]  wcnt_q;
  logic [DIV_W-1:0]    phase_q;
  logic                extra_q;
  logic                fall_q;
  logic                go_q;
  logic                stop_q;

  // Fine reload: programmed fine count, the half-offset correction and the
  // divider phase left over from the coarse stage.
  function automatic logic [FCNT_W-1:0] fine_reload(input logic [FINE_W-1:0] f,
                                                    input logic extra,
                                                    input logic [DIV_W-1:0] ph);
    return FCNT_W'(f) + FCNT_W'(extra) + FCNT_W'(ph);
  endfunction

  function automatic logic [WIDTH_W-1:0] width_reload(input logic [WIDTH_W-1:0] w);
    return (w == '0) ? '0 : w - 1'b1;
  endfunction

  // Free-running divide-by-eight; coarse counting happens only on its tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end
  assign slow_tick = (div_q == {DIV_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ccnt_q  <= '0;
      fcnt_q  <= '0;
      wcnt_q  <= '0;
      phase_q <= '0;
      extra_q <= 1'b0;
      fall_q  <= 1'b0;
      go_q    <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      stop_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            fall_q  <= edge_select(half_i, early_i);
            extra_q <= extra_cycle(half_i, early_i);
            phase_q <= div_q + 1'b1;
            if (coarse_i == '0) begin
              state_q <= SEQ_FINE;
              fcnt_q  <= fine_reload(fine_i, extra_cycle(half_i, early_i), '0);
            end else begin
              state_q <= SEQ_COARSE;
              ccnt_q  <= coarse_i;
            end
          end
        end
        SEQ_COARSE: begin
          if (slow_tick) begin
            if (ccnt_q == COARSE_W'(1)) begin
              state_q <= SEQ_FINE;
              fcnt_q  <= fine_reload(fine_run_i, extra_q, phase_q);
            end else begin
              ccnt_q <= ccnt_q - 1'b1;
            end
          end
        end
        SEQ_FINE: begin
          if (fcnt_q == '0) begin
            go_q    <= 1'b1;
            state_q <= SEQ_PULSE;
            wcnt_q  <= width_reload(width_run_i);
          end else begin
            fcnt_q <= fcnt_q - 1'b1;
          end
        end
        SEQ_PULSE: begin
          if (wcnt_q == '0) begin
            stop_q  <= 1'b1;
            state_q <= SEQ_IDLE;
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != SEQ_IDLE);
  assign go_o        = go_q;
  assign stop_o      = stop_q;
  assign fall_edge_o = fall_q;
endmodule

// File: rtl/tdc_edge_out.sv
`timescale 1ns/1ps
module tdc_edge_out (
  input  logic clk,
  input  logic rst_n,
  input  logic req_rise_i,
  input  logic req_fall_i,
  input  logic invert_i,
  output logic tog_rise_o,
  output logic pulse_o
);
  logic tog_r_q;
  logic tog_f_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tog_r_q <= 1'b0;
    else if (req_rise_i) tog_r_q <= ~tog_r_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)          tog_f_q <= 1'b0;
    else if (req_fall_i) tog_f_q <= ~tog_f_q;
  end

  assign tog_rise_o = tog_r_q;
  assign pulse_o    = tog_r_q ^ tog_f_q ^ invert_i;
endmodule

// File: rtl/trig_delay_channel.sv
`timescale 1ns/1ps
module trig_delay_channel #(
  parameter int COARSE_W = 8,
  parameter int FINE_W   = 3,
  parameter int WIDTH_W  = 8,
  parameter int DATA_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          trig_i,
  input  logic                          wr_en_i,
  input  logic [tdc_pkg::REG_ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic                          pulse_o,
  output logic                          overrun_o
);
  import tdc_pkg::*;

  localparam int CFG_W = COARSE_W + FINE_W + WIDTH_W + 2;

  // Shadow (written) and running (frozen while busy) settings
  logic [COARSE_W-1:0] sh_coarse_q, run_coarse_q;
  logic [FINE_W-1:0]   sh_fine_q,   run_fine_q;
  logic [WIDTH_W-1:0]  sh_width_q,  run_width_q;
  logic                sh_half_q,   run_half_q;
  logic                sh_inv_q,    run_inv_q;
  logic                ovr_q;

  // Named internal events
  logic             det_evt;
  logic             early_evt;
  logic             busy;
  logic             start_evt;
  logic             go_evt;
  logic             stop_evt;
  logic             fall_edge;
  logic             req_rise;
  logic             req_fall;
  logic             tog_rise;
  logic             clr_hit;
  logic [CFG_W-1:0] run_cfg;

  tdc_edge_sampler u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (trig_i),
    .det_o   (det_evt),
    .early_o (early_evt)
  );

  assign start_evt = det_evt & ~busy;

  tdc_sequencer #(
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W),
    .WIDTH_W  (WIDTH_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_evt),
    .early_i     (early_evt),
    .coarse_i    (sh_coarse_q),
    .fine_i      (sh_fine_q),
    .half_i      (sh_half_q),
    .fine_run_i  (run_fine_q),
    .width_run_i (run_width_q),
    .busy_o      (busy),
    .go_o        (go_evt),
    .stop_o      (stop_evt),
    .fall_edge_o (fall_edge)
  );

  assign req_rise = (go_evt | stop_evt) & ~fall_edge;
  assign req_fall = (go_evt | stop_evt) &  fall_edge;

  tdc_edge_out u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_rise_i (req_rise),
    .req_fall_i (req_fall),
    .invert_i   (run_inv_q),
    .tog_rise_o (tog_rise),
    .pulse_o    (pulse_o)
  );

  // Shadow register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_coarse_q <= '0;
      sh_fine_q   <= '0;
      sh_width_q  <= '0;
      sh_half_q   <= 1'b0;
      sh_inv_q    <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        REG_COARSE: sh_coarse_q <= wr_data_i[COARSE_W-1:0];
        REG_FINE:   sh_fine_q   <= wr_data_i[FINE_W-1:0];
        REG_MODE: begin
          sh_half_q <= wr_data_i[0];
          sh_inv_q  <= wr_data_i[1];
        end
        REG_WIDTH:  sh_width_q  <= wr_data_i[WIDTH_W-1:0];
        default: ;
      endcase
    end
  end

  // Running copy follows the shadow only while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_coarse_q <= '0;
      run_fine_q   <= '0;
      run_width_q  <= '0;
      run_half_q   <= 1'b0;
      run_inv_q    <= 1'b0;
    end else if (!busy) begin
      run_coarse_q <= sh_coarse_q;
      run_fine_q   <= sh_fine_q;
      run_width_q  <= sh_width_q;
      run_half_q   <= sh_half_q;
      run_inv_q    <= sh_inv_q;
    end
  end

  assign run_cfg = {run_coarse_q, run_fine_q, run_width_q, run_half_q, run_inv_q};

  // Sticky overrun; a new overrun wins over a clear in the same cycle
  assign clr_hit = wr_en_i & (wr_addr_i == REG_STATUS) & wr_data_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ovr_q <= 1'b0;
    else if (det_evt & busy) ovr_q <= 1'b1;
    else if (clr_hit)        ovr_q <= 1'b0;
  end

  assign overrun_o = ovr_q;
endmodule

// File: rtl/tdc_checker.sv
`timescale 1ns/1ps
module tdc_checker #(
  parameter int CFG_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             det_evt,
  input logic             busy,
  input logic             start_evt,
  input logic             go_evt,
  input logic             stop_evt,
  input logic             req_rise,
  input logic             tog_rise,
  input logic             ovr,
  input logic             clr_hit,
  input logic [CFG_W-1:0] run_cfg
);
  // R2: an accepted trigger makes the channel busy on the next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  // R3: the rising-edge toggle register only moves when asked to
  p_toggle_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tog_rise) |-> $past(req_rise));

  // R4: pulse start and pulse end never coincide
  p_go_stop_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_evt, stop_evt}));

  // R6: a trigger while busy raises the overrun flag
  p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_evt && busy) |=> ovr);

  // R7: the flag only falls through a clear write
  p_ovr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_hit) |=> ovr);

  // R8: running settings are frozen while busy
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(run_cfg));
endmodule

bind trig_delay_channel tdc_checker #(.CFG_W(CFG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .det_evt   (det_evt),
  .busy      (busy),
  .start_evt (start_evt),
  .go_evt    (go_evt),
  .stop_evt  (stop_evt),
  .req_rise  (req_rise),
  .tog_rise  (tog_rise),
  .ovr       (ovr_q),
  .clr_hit   (clr_hit),
  .run_cfg   (run_cfg)
);

// File: tb/trig_delay_channel_tb_top.sv
`timescale 1ns/1ps
module trig_delay_channel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pulse;
  logic       overrun;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    hc     = 0;
  int    exp_rise = -1;
  int    exp_fall = -1;
  bit    chk_on = 1'b0;
  string cur_req = "R1";

  // Behavioural model of the programmed settings
  int m_coarse = 0, m_fine = 0, m_width = 0;
  bit m_half = 0, m_inv = 0;

  always #2.5 clk = ~clk;

  trig_delay_channel dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (trig),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .pulse_o   (pulse),
    .overrun_o (overrun)
  );

  // Edge counter: every clock edge, both directions
  always @(clk) hc = hc + 1;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at edge %0d: actual %b expected %b", req, hc, act, exp);
    end
  endtask

  // Compare against the model after every edge
  always @(clk) begin
    #1;
    if (chk_on) begin
      bit active;
      active = (exp_rise >= 0) && (hc >= exp_rise) && (hc < exp_fall);
      check(cur_req, pulse, active ^ m_inv);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic set_cfg(input int c, input int f, input bit h, input int w);
    wr(3'd0, 8'(c)); m_coarse = c;
    wr(3'd1, 8'(f)); m_fine = f;
    wr(3'd2, {6'd0, m_inv, h}); m_half = h;
    wr(3'd3, 8'(w)); m_width = w;
  endtask

  // Trigger first seen on a falling edge (at_neg) or on a rising edge
  task automatic fire(input bit at_neg, input bit accepted);
    int a;
    if (at_neg) @(posedge clk);
    else        @(negedge clk);
    #0.5;
    trig = 1'b1;
    a = hc + 1;
    if (accepted) begin
      exp_rise = a + 16*m_coarse + 2*m_fine + int'(m_half) + 6;
      exp_fall = exp_rise + 2*((m_width == 0) ? 1 : m_width);
    end
    repeat (2) @(posedge clk);
    #0.5;
    trig = 1'b0;
  endtask

  task automatic wait_done();
    while (hc < exp_fall + 8) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", pulse, 1'b0);
    check("R1", overrun, 1'b0);
    chk_on = 1'b1;

    // R2: zero delay, rising-edge arrival shows the fixed latency
    cur_req = "R2";
    set_cfg(0, 0, 0, 1);
    fire(0, 1); wait_done();
    // R3: zero delay, falling-edge arrival
    cur_req = "R3";
    fire(1, 1); wait_done();

    // R2/R3: coarse + fine + half with both arrival phases
    cur_req = "R2";
    set_cfg(2, 5, 1, 3);
    fire(0, 1); wait_done();
    cur_req = "R3";
    fire(1, 1); wait_done();
    set_cfg(1, 7, 1, 2);
    fire(1, 1); wait_done();
    fire(0, 1); wait_done();

    // R4: zero width is one period; wide pulse
    cur_req = "R4";
    set_cfg(0, 3, 0, 0);
    fire(0, 1); wait_done();
    set_cfg(0, 2, 1, 9);
    fire(1, 1); wait_done();

    // R9: divider phase sweep
    cur_req = "R9";
    set_cfg(1, 3, 0, 2);
    for (int i = 0; i < 8; i++) begin
      repeat (i) @(posedge clk);
      fire(i[0], 1); wait_done();
    end

    // R5: inverted polarity
    chk_on = 1'b0;
    m_inv = 1'b1;
    wr(3'd2, 8'b10);
    m_half = 0;
    repeat (3) @(posedge clk);
    #1 check("R5", pulse, 1'b1);
    cur_req = "R5";
    chk_on = 1'b1;
    set_cfg(0, 4, 1, 3);
    fire(0, 1); wait_done();
    chk_on = 1'b0;
    m_inv = 1'b0;
    wr(3'd2, 8'b00);
    m_half = 0;
    repeat (3) @(posedge clk);
    chk_on = 1'b1;

    // R6: retrigger while busy is dropped and flagged
    cur_req = "R6";
    set_cfg(3, 0, 0, 2);
    #1 check("R6", overrun, 1'b0);
    fire(0, 1);
    repeat (8) @(posedge clk);
    fire(1, 0);
    wait_done();
    #1 check("R6", overrun, 1'b1);

    // R7: write-one-to-clear
    cur_req = "R7";
    wr(3'd4, 8'h00);
    #1 check("R7", overrun, 1'b1);
    wr(3'd4, 8'h01);
    #1 check("R7", overrun, 1'b0);

    // R8: writes during a running delay wait for the next trigger
    cur_req = "R8";
    set_cfg(2, 1, 0, 2);
    fire(0, 1);
    wr(3'd1, 8'd6);
    wr(3'd3, 8'd4);
    wr(3'd2, 8'd1);
    wait_done();
    m_fine = 6; m_width = 4; m_half = 1;
    fire(1, 1); wait_done();
    #1 check("R8", overrun, 1'b0);

    chk_on = 1'b0;
    report();
  end
endmodule